// File: doc/BRIEF.md
# Posted Column Command Scheduler

This block sits on the device side of a synchronous DRAM command path and decides when accepted column commands take effect inside the part. A write executes on the edge after it is accepted. A read is posted: it waits internally for a programmed additive latency (AL) before it executes. After execution, a CAS latency (CL) count runs, and then a read-data-valid window of four beats opens, each beat tagged with its index. The block handles timing only.

AL is loaded through an extended mode write whose 3-bit field decides the value. CL is loaded through a separate mode write. Commands may be issued on consecutive cycles, so several reads can be waiting or counting at once. Two reads whose data windows touch end to end run with no gap cycle. A read that would overlap an earlier window, or that would execute on the same cycle as an earlier posted read, is dropped and flagged.

Top module: `posted_cas_sched`

## Requirements
- R1: After reset, AL is 0, CL is 3, no command is in flight, and every output is low.
- R2: A pulse on `emrs_vld_i` with field `emrs_val_i[5:3]` in the range 0 to 4 sets AL to that value. The other bits of `emrs_val_i` are ignored. Commands accepted on the same edge still use the old AL.
- R3: A field value of 5, 6 or 7, or a CL value outside 2 to 6, leaves the setting unchanged and raises `cfg_err_o` for the one cycle after that edge.
- R4: A pulse on `mrs_vld_i` with `cl_i` in the range 2 to 6 sets CL. Commands accepted on the same edge still use the old CL.
- R5: A write (`cmd_vld_i` with `cmd_wr_i`=1) accepted at edge n raises `exec_wr_o` for the one cycle after edge n, whatever the AL setting.
- R6: A read (`cmd_vld_i` with `cmd_wr_i`=0) accepted at edge n raises `exec_rd_o` for the one cycle after edge n+AL.
- R7: A read that executes at edge m raises `rd_vld_o` for the four cycles after edges m+CL through m+CL+3. During those cycles `rd_beat_o` counts 0, 1, 2, 3. CL is the value in force at edge m.
- R8: Reads whose executions are four or more cycles apart each get a full window. When they are exactly four apart, the windows are back to back with no idle cycle. Writes issued in between do not disturb them.
- R9: A read whose window would share any cycle with an earlier window still raises `exec_rd_o`, but it gets no window. Instead it raises `collide_o` during its `exec_rd_o` cycle.
- R10: A read that would execute on the same edge as an earlier posted read, for example because AL was lowered while a read was waiting, is dropped. It never raises `exec_rd_o`, and it raises `collide_o` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_vld_i | input | 1 | Column command accepted this edge |
| cmd_wr_i | input | 1 | Command type: 1 write, 0 read |
| emrs_vld_i | input | 1 | Extended mode write strobe |
| emrs_val_i | input | 13 | Extended mode word; AL field at bits 5:3 |
| mrs_vld_i | input | 1 | Mode write strobe for CL |
| cl_i | input | 3 | CAS latency value |
| exec_rd_o | output | 1 | Read takes internal effect |
| exec_wr_o | output | 1 | Write takes internal effect |
| rd_vld_o | output | 1 | Read data valid window |
| rd_beat_o | output | 2 | Beat index within the window |
| collide_o | output | 1 | A read was dropped |
| cfg_err_o | output | 1 | Reserved or out-of-range setting rejected |

## Verification
The bench sweeps every legal pair of AL and CL. For each pair it checks the exact execute cycle and the exact window cycles. A design that added AL to writes, or that counted CL from acceptance instead of from execution, would place a pulse one or more cycles off. Read spacings of 3, 4 and 5 cycles are exercised: an off-by-one in the overlap test would either flag the clean back-to-back case or let overlapping windows corrupt the beat index. The reserved field values and out-of-range CL values are each followed by a read that exposes the setting, because a design that loaded them anyway would move that read's timing. Lowering AL under a waiting read is also exercised; a design without the execute-slot check would emit two reads in one cycle.

// File: rtl/posted_cas_pkg.sv
package posted_cas_pkg;

    localparam int unsigned SET_W     = 3;
    localparam int unsigned AL_LIMIT  = 4;
    localparam logic [SET_W-1:0] CL_AT_RESET = 3'd3;

    typedef struct packed {
        logic [SET_W-1:0] al;
        logic [SET_W-1:0] cl;
        logic             err;
    } cfg_state_t;

endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
    import posted_cas_pkg::*;
#(
    parameter int unsigned EMRS_W = 13,
    parameter int unsigned AL_LSB = 3,
    parameter int unsigned CL_MIN = 2,
    parameter int unsigned CL_MAX = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             emrs_vld_i,
    input  logic [EMRS_W-1:0] emrs_val_i,
    input  logic             mrs_vld_i,
    input  logic [SET_W-1:0] cl_i,
    output logic [SET_W-1:0] al_o,
    output logic [SET_W-1:0] cl_o,
    output logic             err_o
);

    cfg_state_t s_d, s_q;
    logic [SET_W-1:0] al_field;

    assign al_field = emrs_val_i[AL_LSB +: SET_W];

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (emrs_vld_i) begin
            if (al_field <= SET_W'(AL_LIMIT)) begin
                s_d.al = al_field;
            end else begin
                s_d.err = 1'b1;
            end
        end
        if (mrs_vld_i) begin
            if ((cl_i >= SET_W'(CL_MIN)) && (cl_i <= SET_W'(CL_MAX))) begin
                s_d.cl = cl_i;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.al  <= '0;
            s_q.cl  <= CL_AT_RESET;
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign al_o  = s_q.al;
    assign cl_o  = s_q.cl;
    assign err_o = s_q.err;

endmodule

// File: rtl/pcs_post_line.sv
module pcs_post_line
    import posted_cas_pkg::*;
#(
    parameter int unsigned AL_MAX = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_vld_i,
    input  logic             cmd_wr_i,
    input  logic [SET_W-1:0] al_i,
    output logic             fire_o,
    output logic             clash_o,
    output logic             exec_rd_o,
    output logic             exec_wr_o
);

    localparam int unsigned DEPTH = (AL_MAX < 1) ? 1 : AL_MAX;

    typedef struct packed {
        logic [DEPTH-1:0] pend;
        logic             rd;
        logic             wr;
    } line_t;

    line_t s_d, s_q;
    logic [DEPTH-1:0] shifted;
    logic             new_rd;
    logic             fire;
    logic             clash;

    assign new_rd = cmd_vld_i & ~cmd_wr_i;

    always_comb begin
        shifted = s_q.pend >> 1;
        fire    = s_q.pend[0];
        clash   = 1'b0;
        if (new_rd) begin
            if (al_i == '0) begin
                if (s_q.pend[0]) begin
                    clash = 1'b1;
                end else begin
                    fire = 1'b1;
                end
            end else begin
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (i == int'(al_i) - 1) begin
                        if (shifted[i]) begin
                            clash = 1'b1;
                        end else begin
                            shifted[i] = 1'b1;
                        end
                    end
                end
            end
        end
        s_d.pend = shifted;
        s_d.rd   = fire;
        s_d.wr   = cmd_vld_i & cmd_wr_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fire_o    = fire;
    assign clash_o   = clash;
    assign exec_rd_o = s_q.rd;
    assign exec_wr_o = s_q.wr;

endmodule

// File: rtl/pcs_burst_sched.sv
module pcs_burst_sched
    import posted_cas_pkg::*;
#(
    parameter int unsigned CL_MAX = 6,
    parameter int unsigned BURST  = 4,
    localparam int unsigned BEAT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fire_i,
    input  logic              clash_i,
    input  logic [SET_W-1:0]  cl_i,
    output logic              rd_vld_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              collide_o
);

    localparam int unsigned SPAN = CL_MAX + BURST - 1;

    typedef struct packed {
        logic [SPAN-1:0]             occ;
        logic [SPAN-1:0][BEAT_W-1:0] bt;
        logic                        vld;
        logic [BEAT_W-1:0]           beat;
        logic                        col;
    } win_t;

    win_t s_d, s_q;
    logic [SPAN-1:0]             occ_sh;
    logic [SPAN-1:0][BEAT_W-1:0] bt_sh;
    logic [SPAN-1:0]             ins;
    logic                        hit;

    always_comb begin
        occ_sh = s_q.occ >> 1;
        for (int i = 0; i < int'(SPAN); i++) begin
            bt_sh[i] = (i + 1 < int'(SPAN)) ? s_q.bt[i+1] : '0;
        end
        ins = '0;
        for (int i = 0; i < int'(SPAN); i++) begin
            if ((i >= int'(cl_i) - 1) && (i < int'(cl_i) - 1 + int'(BURST))) begin
                ins[i] = 1'b1;
            end
        end
        hit = |(ins & occ_sh);

        s_d      = s_q;
        s_d.occ  = occ_sh;
        s_d.bt   = bt_sh;
        if (fire_i && !hit) begin
            for (int i = 0; i < int'(SPAN); i++) begin
                if (ins[i]) begin
                    s_d.occ[i] = 1'b1;
                    s_d.bt[i]  = BEAT_W'(i - (int'(cl_i) - 1));
                end
            end
        end
        s_d.vld  = s_q.occ[0];
        s_d.beat = s_q.occ[0] ? s_q.bt[0] : '0;
        s_d.col  = clash_i | (fire_i & hit);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_vld_o  = s_q.vld;
    assign beat_o    = s_q.beat;
    assign collide_o = s_q.col;

endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
    import posted_cas_pkg::*;
#(
    parameter int unsigned EMRS_W = 13,
    parameter int unsigned AL_LSB = 3,
    parameter int unsigned CL_MIN = 2,
    parameter int unsigned CL_MAX = 6,
    parameter int unsigned BURST  = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cmd_vld_i,
    input  logic                     cmd_wr_i,
    input  logic                     emrs_vld_i,
    input  logic [EMRS_W-1:0]        emrs_val_i,
    input  logic                     mrs_vld_i,
    input  logic [2:0]               cl_i,
    output logic                     exec_rd_o,
    output logic                     exec_wr_o,
    output logic                     rd_vld_o,
    output logic [$clog2(BURST)-1:0] rd_beat_o,
    output logic                     collide_o,
    output logic                     cfg_err_o
);

    logic [SET_W-1:0] al_w;
    logic [SET_W-1:0] cl_w;
    logic             fire_w;
    logic             clash_w;

    pcs_cfg_regs #(
        .EMRS_W (EMRS_W),
        .AL_LSB (AL_LSB),
        .CL_MIN (CL_MIN),
        .CL_MAX (CL_MAX)
    ) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .emrs_vld_i (emrs_vld_i),
        .emrs_val_i (emrs_val_i),
        .mrs_vld_i  (mrs_vld_i),
        .cl_i       (cl_i),
        .al_o       (al_w),
        .cl_o       (cl_w),
        .err_o      (cfg_err_o)
    );

    pcs_post_line #(
        .AL_MAX (AL_LIMIT)
    ) post_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cmd_vld_i (cmd_vld_i),
        .cmd_wr_i  (cmd_wr_i),
        .al_i      (al_w),
        .fire_o    (fire_w),
        .clash_o   (clash_w),
        .exec_rd_o (exec_rd_o),
        .exec_wr_o (exec_wr_o)
    );

    pcs_burst_sched #(
        .CL_MAX (CL_MAX),
        .BURST  (BURST)
    ) win_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (fire_w),
        .clash_i   (clash_w),
        .cl_i      (cl_w),
        .rd_vld_o  (rd_vld_o),
        .beat_o    (rd_beat_o),
        .collide_o (collide_o)
    );

endmodule

// File: rtl/posted_cas_chk.sv
module posted_cas_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        cmd_vld_i,
    input logic        cmd_wr_i,
    input logic        emrs_vld_i,
    input logic [12:0] emrs_val_i,
    input logic        exec_rd_o,
    input logic        exec_wr_o,
    input logic        rd_vld_o,
    input logic [1:0]  rd_beat_o,
    input logic        cfg_err_o,
    input logic [2:0]  al_i,
    input logic [2:0]  cl_i
);

    AST_WR_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_vld_i && cmd_wr_i |=> exec_wr_o); // R5

    AST_RD_NO_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_vld_i && !cmd_wr_i && (al_i == 3'd0) |=> exec_rd_o); // R6

    AST_RESERVED_AL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        emrs_vld_i && (emrs_val_i[5:3] > 3'd4) |=> cfg_err_o && (al_i == $past(al_i))); // R3

    AST_AL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        al_i <= 3'd4); // R2

    AST_CL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cl_i >= 3'd2) && (cl_i <= 3'd6)); // R4

    AST_BEAT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_vld_o) |-> rd_beat_o == 2'd0); // R7

    AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_vld_o && (rd_beat_o != 2'd3) |=> rd_vld_o && (rd_beat_o == 2'($past(rd_beat_o) + 2'd1))); // R7

endmodule

bind posted_cas_sched posted_cas_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_wr_i   (cmd_wr_i),
    .emrs_vld_i (emrs_vld_i),
    .emrs_val_i (emrs_val_i),
    .exec_rd_o  (exec_rd_o),
    .exec_wr_o  (exec_wr_o),
    .rd_vld_o   (rd_vld_o),
    .rd_beat_o  (rd_beat_o),
    .cfg_err_o  (cfg_err_o),
    .al_i       (al_w),
    .cl_i       (cl_w)
);

// File: tb/posted_cas_sched_tb_top.sv
module posted_cas_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_vld, cmd_wr, emrs_vld, mrs_vld;
    logic [12:0] emrs_val;
    logic [2:0]  cl_set;
    logic        exec_rd, exec_wr, rd_vld, collide, cfg_err;
    logic [1:0]  rd_beat;

    always #10 clk = ~clk;

    posted_cas_sched dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cmd_vld_i  (cmd_vld),
        .cmd_wr_i   (cmd_wr),
        .emrs_vld_i (emrs_vld),
        .emrs_val_i (emrs_val),
        .mrs_vld_i  (mrs_vld),
        .cl_i       (cl_set),
        .exec_rd_o  (exec_rd),
        .exec_wr_o  (exec_wr),
        .rd_vld_o   (rd_vld),
        .rd_beat_o  (rd_beat),
        .collide_o  (collide),
        .cfg_err_o  (cfg_err)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    int    base   = 0;
    bit    done   = 1'b0;
    string seg    = "R1";
    int    al_m   = 0;
    int    cl_m   = 3;

    bit e_rd [256];
    bit e_wr [256];
    bit e_vld[256];
    bit e_col[256];
    bit e_err[256];
    int e_beat[256];

    task automatic chk(input string sig, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at step %0d: actual=%0d expected=%0d", seg, sig, cyc - base, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 256; i++) begin
            e_rd[i] = 0; e_wr[i] = 0; e_vld[i] = 0; e_col[i] = 0; e_err[i] = 0; e_beat[i] = 0;
        end
        base = cyc;
    endtask

    task automatic compare();
        int k;
        k = cyc - base;
        if (k > 255) k = 255;
        chk("R6 exec_rd", int'(exec_rd), int'(e_rd[k]));
        chk("R5 exec_wr", int'(exec_wr), int'(e_wr[k]));
        chk("R7 rd_vld", int'(rd_vld), int'(e_vld[k]));
        if (e_vld[k]) chk("R7 rd_beat", int'(rd_beat), e_beat[k]);
        chk("R9 collide", int'(collide), int'(e_col[k]));
        chk("R3 cfg_err", int'(cfg_err), int'(e_err[k]));
    endtask

    function automatic logic [12:0] mk_emrs(input int f);
        return {7'h2A, 3'(f), 3'b101};
    endfunction

    task automatic tick(input bit cv, input bit cw, input bit ev, input logic [12:0] evl,
                        input bit mv, input logic [2:0] clv);
        int  e, x, s;
        bit  ovl;
        e = cyc - base + 1;
        cmd_vld = cv; cmd_wr = cw; emrs_vld = ev; emrs_val = evl; mrs_vld = mv; cl_set = clv;
        if (cv && cw) e_wr[e] = 1;
        if (cv && !cw) begin
            x = e + al_m;
            if (e_rd[x]) begin
                e_col[e] = 1;
            end else begin
                e_rd[x] = 1;
                s = x + cl_m;
                ovl = 0;
                for (int b = 0; b < 4; b++) if (e_vld[s + b]) ovl = 1;
                if (ovl) begin
                    e_col[x] = 1;
                end else begin
                    for (int b = 0; b < 4; b++) begin
                        e_vld[s + b]  = 1;
                        e_beat[s + b] = b;
                    end
                end
            end
        end
        if (ev) begin
            if (int'(evl[5:3]) <= 4) al_m = int'(evl[5:3]); else e_err[e] = 1;
        end
        if (mv) begin
            if (clv >= 3'd2 && clv <= 3'd6) cl_m = int'(clv); else e_err[e] = 1;
        end
        @(posedge clk);
        cyc++;
        #1;
        cmd_vld = 0; cmd_wr = 0; emrs_vld = 0; emrs_val = '0; mrs_vld = 0; cl_set = '0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, '0, 0, '0);
    endtask

    task automatic rd();
        tick(1, 0, 0, '0, 0, '0);
    endtask

    task automatic wr();
        tick(1, 1, 0, '0, 0, '0);
    endtask

    task automatic set_al(input int f);
        tick(0, 0, 1, mk_emrs(f), 0, '0);
    endtask

    task automatic set_cl(input int c);
        tick(0, 0, 0, '0, 1, 3'(c));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0;
        cmd_vld = 0; cmd_wr = 0; emrs_vld = 0; emrs_val = '0; mrs_vld = 0; cl_set = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        cyc = 0;
        clear_model();
        // R1: quiet outputs straight out of reset
        compare();
        // R1: defaults AL=0, CL=3 seen through the first read's timing
        rd();
        wr();
        idle(12);

        // R2, R4, R5, R6, R7: every legal AL and CL pair
        seg = "R2/R4/R6/R7 sweep";
        for (int a = 0; a <= 4; a++) begin
            for (int c = 2; c <= 6; c++) begin
                clear_model();
                set_al(a);
                set_cl(c);
                rd();
                wr();
                idle(16);
            end
        end

        // R3: reserved AL fields and out-of-range CL leave settings alone
        seg = "R3";
        clear_model();
        set_al(1);
        set_cl(2);
        for (int f = 5; f <= 7; f++) set_al(f);
        set_cl(0);
        set_cl(1);
        set_cl(7);
        rd();
        idle(12);

        // R8: reads four apart with writes between, then five apart
        seg = "R8";
        clear_model();
        set_al(2);
        set_cl(4);
        rd(); idle(3);
        rd(); wr(); idle(2);
        rd(); idle(4);
        rd(); wr(); wr(); wr();
        rd();
        idle(16);

        // R9: reads three and one cycles apart overlap a live window
        seg = "R9";
        clear_model();
        set_al(0);
        set_cl(3);
        rd(); idle(2);
        rd();
        rd();
        idle(16);

        // R10: lowering AL under a waiting read forces a shared execute slot
        seg = "R10";
        clear_model();
        set_al(4);
        rd();
        set_al(2);
        rd();
        idle(14);
        set_al(1);
        rd();
        set_al(0);
        rd();
        idle(14);

        finish_run();
    end

endmodule